// File: doc/BRIEF.md
# Top-Two Hit Quality Selector

This block sits at the end of a template-matching pipeline. For each search offset of a match task it receives two counts. The bright count is the number of chip pixels under set bright-mask bits that pass the intensity test. The surround count is the number of chip pixels under set surround-mask bits that fail it. The block decides whether the offset is a hit, scores it, and keeps only the two best hits of the task.

A task opens with a start strobe. The strobe carries the chip and mask identifiers, the number of set bits in each mask, and two minimum match percentages. The counts then stream in, one offset per valid beat, each beat with its offset. An end strobe closes the task. One cycle after the end strobe, the block shows both kept hits in descending score order for a single cycle, together with a done flag. A perfect match scores 100, and each of the two counts contributes at most half of that.

Top module: `hit_top2_select`

## Requirements
- R1: While reset is asserted and after its release, `done_o` is low and every result output is zero until the first end strobe.
- R2: The score of an offset is floor(50*bright_cnt/bright_total) + floor(50*surround_cnt/surround_total). Each term is floored on its own. A term whose total is zero is 0. A perfect match scores 100.
- R3: An offset is a hit only when 100*bright_cnt >= bright_min_pct*bright_total and 100*surround_cnt >= surround_min_pct*surround_total. Offsets that are not hits never enter a slot.
- R4: Slot 0 holds the highest-scoring hit of the task and slot 1 the second highest. A new hit that beats slot 0 pushes slot 0 down into slot 1.
- R5: On equal scores, the hit that arrived first keeps the higher rank. A later hit must score strictly higher to displace a kept hit.
- R6: Each kept hit reports the chip and mask identifiers sampled at the task's start strobe and the offset of its own beat.
- R7: Each slot has a valid bit. With fewer than two hits, the unused slot reports valid 0 and all of its fields zero.
- R8: A start strobe empties both slots. A count beat in the same cycle as a start strobe is dropped.
- R9: The end strobe raises `done_o` exactly one cycle later, for one cycle, with the results. A count beat in the same cycle as the end strobe is included. While `done_o` is low, all result outputs are zero.
- R10: Totals, minimum percentages and identifiers are sampled only at the start strobe. Changing them during a task has no effect on that task.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_start | input | 1 | Opens a task; samples the task parameters |
| task_end | input | 1 | Closes a task; results follow one cycle later |
| chip_id_i | input | 8 | Chip identifier of the task |
| mask_id_i | input | 8 | Mask identifier of the task |
| bright_total_i | input | 10 | Set bits in the bright mask |
| surround_total_i | input | 10 | Set bits in the surround mask |
| bright_min_pct_i | input | 7 | Minimum bright match, in percent |
| surround_min_pct_i | input | 7 | Minimum surround match, in percent |
| cnt_valid | input | 1 | A count beat is present |
| bright_cnt | input | 10 | Bright count of the beat |
| surround_cnt | input | 10 | Surround count of the beat |
| offset_i | input | 10 | Search offset of the beat |
| done_o | output | 1 | Results valid, one cycle |
| hit0_valid | output | 1 | Slot 0 holds a hit |
| hit0_chip | output | 8 | Slot 0 chip identifier |
| hit0_mask | output | 8 | Slot 0 mask identifier |
| hit0_offset | output | 10 | Slot 0 offset |
| hit0_score | output | 7 | Slot 0 score |
| hit1_valid | output | 1 | Slot 1 holds a hit |
| hit1_chip | output | 8 | Slot 1 chip identifier |
| hit1_mask | output | 8 | Slot 1 mask identifier |
| hit1_offset | output | 10 | Slot 1 offset |
| hit1_score | output | 7 | Slot 1 score |

## Verification
The bench builds the block with the package defaults: 10-bit counts and offsets, 8-bit identifiers and 7-bit percentages. Mask totals of 20 and 40 make half-step quotients such as 37.5 reachable, so per-term flooring (74 rather than 75) is visible. They also make exact threshold boundaries reachable at 50 percent: a bright count of 10 passes and 9 fails. A zero surround total with a zero minimum exercises the empty-term case. Short tasks of one to three beats cover every slot transition, ties, empty slots, and strobes that coincide with beats.

// File: rtl/hq_pkg.sv
package hq_pkg;
  parameter int CHIP_W  = 8;
  parameter int MASK_W  = 8;
  parameter int OFF_W   = 10;
  parameter int CNT_W   = 10;
  parameter int PCT_W   = 7;
  parameter int SCORE_W = 7;
  parameter int HALF_SCORE = 50;
  parameter int FULL_PCT   = 100;

  typedef struct packed {
    logic               vld;
    logic [CHIP_W-1:0]  chip;
    logic [MASK_W-1:0]  mask;
    logic [OFF_W-1:0]   off;
    logic [SCORE_W-1:0] score;
  } hit_t;
endpackage

// File: rtl/hq_score.sv
module hq_score
  import hq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   br_cnt,
  input  logic [CNT_W-1:0]   su_cnt,
  input  logic [CNT_W-1:0]   br_tot,
  input  logic [CNT_W-1:0]   su_tot,
  input  logic [PCT_W-1:0]   br_min,
  input  logic [PCT_W-1:0]   su_min,
  output logic [SCORE_W-1:0] score,
  output logic               is_hit
);
  localparam int NUM_W  = CNT_W + 7;
  localparam int PROD_W = CNT_W + PCT_W + 1;

  logic [CNT_W-1:0]   cnt_a [2];
  logic [CNT_W-1:0]   tot_a [2];
  logic [PCT_W-1:0]   min_a [2];
  logic [SCORE_W-1:0] term  [2];
  logic [1:0]         pass;

  assign cnt_a[0] = br_cnt; assign cnt_a[1] = su_cnt;
  assign tot_a[0] = br_tot; assign tot_a[1] = su_tot;
  assign min_a[0] = br_min; assign min_a[1] = su_min;

  for (genvar g = 0; g < 2; g++) begin : g_term
    logic [NUM_W-1:0]  num;
    logic [NUM_W-1:0]  quo;
    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;
    always_comb begin
      num = NUM_W'(cnt_a[g]) * NUM_W'(HALF_SCORE);
      quo = (tot_a[g] == '0) ? '0 : num / NUM_W'(tot_a[g]);
      term[g] = quo[SCORE_W-1:0];
      lhs = PROD_W'(cnt_a[g]) * PROD_W'(FULL_PCT);
      rhs = PROD_W'(min_a[g]) * PROD_W'(tot_a[g]);
      pass[g] = (lhs >= rhs);
    end
  end

  assign score  = term[0] + term[1];
  assign is_hit = &pass;

  // R2: counts within their totals never score above a perfect match
  assert_score_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_cnt <= br_tot && su_cnt <= su_tot) |-> (score <= SCORE_W'(2*HALF_SCORE)));
endmodule

// File: rtl/hq_rank.sv
module hq_rank
  import hq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ins,
  input  hit_t cand,
  output hit_t slot0_nx,
  output hit_t slot1_nx
);
  hit_t slot0_q, slot1_q;

  always_comb begin
    slot0_nx = slot0_q;
    slot1_nx = slot1_q;
    if (clr) begin
      slot0_nx = '0;
      slot1_nx = '0;
    end else if (ins) begin
      if (!slot0_q.vld || cand.score > slot0_q.score) begin
        slot1_nx = slot0_q;
        slot0_nx = cand;
      end else if (!slot1_q.vld || cand.score > slot1_q.score) begin
        slot1_nx = cand;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0_q <= '0;
      slot1_q <= '0;
    end else begin
      slot0_q <= slot0_nx;
      slot1_q <= slot1_nx;
    end
  end

  // R4: kept hits stay in descending order
  assert_desc_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot0_q.vld && slot1_q.vld) |-> (slot0_q.score >= slot1_q.score));
  // R7: the second slot is never filled ahead of the first
  assert_fill_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot1_q.vld |-> slot0_q.vld);
  // R8: a start strobe leaves both slots empty
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!slot0_q.vld && !slot1_q.vld));
endmodule

// File: rtl/hit_top2_select.sv
module hit_top2_select
  import hq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               task_start,
  input  logic               task_end,
  input  logic [CHIP_W-1:0]  chip_id_i,
  input  logic [MASK_W-1:0]  mask_id_i,
  input  logic [CNT_W-1:0]   bright_total_i,
  input  logic [CNT_W-1:0]   surround_total_i,
  input  logic [PCT_W-1:0]   bright_min_pct_i,
  input  logic [PCT_W-1:0]   surround_min_pct_i,
  input  logic               cnt_valid,
  input  logic [CNT_W-1:0]   bright_cnt,
  input  logic [CNT_W-1:0]   surround_cnt,
  input  logic [OFF_W-1:0]   offset_i,
  output logic               done_o,
  output logic               hit0_valid,
  output logic [CHIP_W-1:0]  hit0_chip,
  output logic [MASK_W-1:0]  hit0_mask,
  output logic [OFF_W-1:0]   hit0_offset,
  output logic [SCORE_W-1:0] hit0_score,
  output logic               hit1_valid,
  output logic [CHIP_W-1:0]  hit1_chip,
  output logic [MASK_W-1:0]  hit1_mask,
  output logic [OFF_W-1:0]   hit1_offset,
  output logic [SCORE_W-1:0] hit1_score
);
  // task parameters, sampled at the start strobe
  logic [CHIP_W-1:0] chip_q;
  logic [MASK_W-1:0] mask_q;
  logic [CNT_W-1:0]  br_tot_q, su_tot_q;
  logic [PCT_W-1:0]  br_min_q, su_min_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_q   <= '0;
      mask_q   <= '0;
      br_tot_q <= '0;
      su_tot_q <= '0;
      br_min_q <= '0;
      su_min_q <= '0;
    end else if (task_start) begin
      chip_q   <= chip_id_i;
      mask_q   <= mask_id_i;
      br_tot_q <= bright_total_i;
      su_tot_q <= surround_total_i;
      br_min_q <= bright_min_pct_i;
      su_min_q <= surround_min_pct_i;
    end
  end

  logic [SCORE_W-1:0] beat_score;
  logic               beat_hit;

  hq_score u_score (
    .clk    (clk),
    .rst_n  (rst_n),
    .br_cnt (bright_cnt),
    .su_cnt (surround_cnt),
    .br_tot (br_tot_q),
    .su_tot (su_tot_q),
    .br_min (br_min_q),
    .su_min (su_min_q),
    .score  (beat_score),
    .is_hit (beat_hit)
  );

  hit_t cand;
  logic ins;
  hit_t slot0_nx, slot1_nx;

  always_comb begin
    cand.vld   = 1'b1;
    cand.chip  = chip_q;
    cand.mask  = mask_q;
    cand.off   = offset_i;
    cand.score = beat_score;
    ins        = cnt_valid && beat_hit && !task_start;
  end

  hq_rank u_rank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (task_start),
    .ins      (ins),
    .cand     (cand),
    .slot0_nx (slot0_nx),
    .slot1_nx (slot1_nx)
  );

  // result stage
  logic done_d, done_q;
  hit_t res0_d, res1_d, res0_q, res1_q;

  always_comb begin
    done_d = task_end;
    res0_d = task_end ? slot0_nx : '0;
    res1_d = task_end ? slot1_nx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res0_q <= '0;
      res1_q <= '0;
    end else begin
      done_q <= done_d;
      res0_q <= res0_d;
      res1_q <= res1_d;
    end
  end

  assign done_o      = done_q;
  assign hit0_valid  = res0_q.vld;
  assign hit0_chip   = res0_q.chip;
  assign hit0_mask   = res0_q.mask;
  assign hit0_offset = res0_q.off;
  assign hit0_score  = res0_q.score;
  assign hit1_valid  = res1_q.vld;
  assign hit1_chip   = res1_q.chip;
  assign hit1_mask   = res1_q.mask;
  assign hit1_offset = res1_q.off;
  assign hit1_score  = res1_q.score;

  // R9: done follows the end strobe by one cycle
  assert_done_follows_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    task_end |=> done_o);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !task_end |=> !done_o);
  // R9: result outputs are quiet outside the done cycle
  assert_quiet_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (!hit0_valid && !hit1_valid && hit0_score == '0 && hit1_offset == '0));
endmodule

// File: tb/hit_top2_select_test.sv
`timescale 1ns/100ps
module hit_top2_select_test;
  logic clk = 1'b0;
  logic rst_n;
  logic task_start, task_end, cnt_valid;
  logic [7:0] chip_id_i, mask_id_i;
  logic [9:0] bright_total_i, surround_total_i, bright_cnt, surround_cnt, offset_i;
  logic [6:0] bright_min_pct_i, surround_min_pct_i;
  logic done_o, hit0_valid, hit1_valid;
  logic [7:0] hit0_chip, hit0_mask, hit1_chip, hit1_mask;
  logic [9:0] hit0_offset, hit1_offset;
  logic [6:0] hit0_score, hit1_score;

  int checks = 0;
  int failures = 0;
  logic [7:0] cur_chip, cur_mask;

  always #2.5 clk = ~clk;

  hit_top2_select uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_task(input int chip, input int mask, input int bt, input int st,
                            input int bm, input int sm);
    chip_id_i = 8'(chip); mask_id_i = 8'(mask);
    bright_total_i = 10'(bt); surround_total_i = 10'(st);
    bright_min_pct_i = 7'(bm); surround_min_pct_i = 7'(sm);
    cur_chip = 8'(chip); cur_mask = 8'(mask);
    task_start = 1'b1;
    @(negedge clk);
    task_start = 1'b0;
  endtask

  task automatic beat(input int b, input int s, input int off);
    cnt_valid = 1'b1; bright_cnt = 10'(b); surround_cnt = 10'(s); offset_i = 10'(off);
    @(negedge clk);
    cnt_valid = 1'b0;
  endtask

  // end strobe; returns at the negedge where done should be high
  task automatic end_task();
    task_end = 1'b1;
    @(negedge clk);
    task_end = 1'b0;
  endtask

  task automatic expect_res(input string req, input int v0, input int o0, input int s0,
                            input int v1, input int o1, input int s1);
    chk({req, " done"}, int'(done_o), 1);
    chk({req, " valid0"}, int'(hit0_valid), v0);
    chk({req, " offset0"}, int'(hit0_offset), v0 ? o0 : 0);
    chk({req, " score0"}, int'(hit0_score), v0 ? s0 : 0);
    chk({req, " R6 chip0"}, int'(hit0_chip), v0 ? int'(cur_chip) : 0);
    chk({req, " R6 mask0"}, int'(hit0_mask), v0 ? int'(cur_mask) : 0);
    chk({req, " valid1"}, int'(hit1_valid), v1);
    chk({req, " offset1"}, int'(hit1_offset), v1 ? o1 : 0);
    chk({req, " score1"}, int'(hit1_score), v1 ? s1 : 0);
    chk({req, " R6 chip1"}, int'(hit1_chip), v1 ? int'(cur_chip) : 0);
  endtask

  task automatic t_reset();
    chk("R1 done", int'(done_o), 0);
    chk("R1 valid0", int'(hit0_valid), 0);
    chk("R1 valid1", int'(hit1_valid), 0);
    chk("R1 score0", int'(hit0_score), 0);
  endtask

  // scores with totals 20/40: (15,30)=74, (20,40)=100, (18,20)=70, (10,20)=50
  task automatic t_two_hits();
    start_task(11, 21, 20, 40, 50, 50);
    beat(15, 30, 1);
    beat(20, 40, 2);
    end_task();
    expect_res("R2 R4 two", 1, 2, 100, 1, 1, 74);
  endtask

  task automatic t_three_hits();
    start_task(12, 22, 20, 40, 50, 50);
    beat(18, 20, 5);
    beat(20, 40, 6);
    beat(15, 30, 7);
    end_task();
    expect_res("R4 three", 1, 6, 100, 1, 7, 74);
  endtask

  task automatic t_tie();
    start_task(13, 23, 20, 40, 50, 50);
    beat(15, 30, 3);
    beat(15, 30, 4);
    beat(18, 20, 5);
    end_task();
    expect_res("R5 tie", 1, 3, 74, 1, 4, 74);
  endtask

  task automatic t_threshold();
    start_task(14, 24, 20, 40, 50, 50);
    beat(9, 40, 7);
    beat(20, 19, 8);
    beat(10, 20, 9);
    end_task();
    expect_res("R3 R7 threshold", 1, 9, 50, 0, 0, 0);
  endtask

  task automatic t_none();
    start_task(15, 25, 20, 40, 90, 90);
    beat(15, 30, 1);
    end_task();
    expect_res("R7 none", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_start_clear();
    start_task(16, 26, 20, 40, 50, 50);
    beat(20, 40, 1);
    // new task whose start coincides with a perfect beat
    cnt_valid = 1'b1; bright_cnt = 10'd20; surround_cnt = 10'd40; offset_i = 10'd2;
    start_task(17, 27, 20, 40, 50, 50);
    cnt_valid = 1'b0;
    end_task();
    expect_res("R8 clear", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_end_beat();
    start_task(18, 28, 20, 40, 50, 50);
    beat(15, 30, 4);
    cnt_valid = 1'b1; bright_cnt = 10'd20; surround_cnt = 10'd40; offset_i = 10'd5;
    end_task();
    cnt_valid = 1'b0;
    expect_res("R9 end beat", 1, 5, 100, 1, 4, 74);
    @(negedge clk);
    chk("R9 done one cycle", int'(done_o), 0);
    chk("R9 quiet valid0", int'(hit0_valid), 0);
    chk("R9 quiet offset0", int'(hit0_offset), 0);
  endtask

  task automatic t_latch();
    start_task(19, 29, 20, 40, 50, 50);
    bright_min_pct_i = 7'd100; surround_min_pct_i = 7'd100;
    bright_total_i = 10'd5; chip_id_i = 8'd99;
    beat(10, 20, 12);
    end_task();
    expect_res("R10 latch", 1, 12, 50, 0, 0, 0);
  endtask

  task automatic t_zero_total();
    start_task(20, 30, 20, 0, 50, 0);
    beat(20, 7, 3);
    end_task();
    expect_res("R2 zero total", 1, 3, 50, 0, 0, 0);
  endtask

  initial begin
    #20000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; task_start = 1'b0; task_end = 1'b0; cnt_valid = 1'b0;
    chip_id_i = '0; mask_id_i = '0; bright_total_i = '0; surround_total_i = '0;
    bright_min_pct_i = '0; surround_min_pct_i = '0;
    bright_cnt = '0; surround_cnt = '0; offset_i = '0;
    cur_chip = '0; cur_mask = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_two_hits();
    t_three_hits();
    t_tie();
    t_threshold();
    t_none();
    t_start_clear();
    t_end_beat();
    t_latch();
    t_zero_total();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule